// File: doc/BRIEF.md
# Read-Address Sequence Command Unlock

This block sits beside a byte-wide SRAM port and watches every access on it. A nonvolatile transfer is unlocked only by six reads in a fixed order. The first five addresses are the same for both commands. The address of the sixth read chooses the command: it either requests that the SRAM contents be saved to the nonvolatile array (store) or that they be reloaded from it (recall).

Any access that does not continue the pattern throws away the progress made so far. A write always breaks the pattern, even when its address matches. The block issues each command as a single-cycle request pulse to a separate transfer engine, which is not part of this block. While that engine reports busy, the detector stays idle and ignores all accesses.

The block has no output-enable input. A read counts purely from its strobe and its read indication.

Top module: `nv_unlock_seq`

## Requirements
- R1: While reset is asserted, and on the first sampled cycle after reset, store_req and recall_req are 0 and the detector is idle (no step is yet matched).
- R2: Reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0, on consecutive accesses, raise store_req for exactly one cycle. The pulse appears in the cycle that follows the clock edge at which the sixth access is sampled.
- R3: The same five reads followed by a read at 0x4C63 raise recall_req for exactly one cycle, with the same timing as R2.
- R4: A read at any address other than the one expected at the current step aborts the sequence. No command is issued for that partial sequence.
- R5: A write (acc_wr=1) never counts as a step. A write inside the sequence aborts it, even when its address equals the expected one.
- R6: An aborting read at 0x4E38 is itself counted as step one of a new sequence.
- R7: While busy is 1, accesses are ignored, no request is issued, and the detector returns to idle.
- R8: An access is sampled once, at the clock edge where acc_valid is 1 and was 0 at the previous edge. Holding acc_valid high does not repeat the access.
- R9: store_req and recall_req are never high together, and each is high for at most one cycle per access.
- R10: After a command is issued, the detector is idle. A further sixth-step address alone issues nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe; its rising edge marks one access |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 16 | Access address |
| busy | input | 1 | Transfer in progress; blocks and clears detection |
| store_req | output | 1 | One-cycle store command pulse |
| recall_req | output | 1 | One-cycle recall command pulse |

## Verification
Two events can land on the same edge: the sixth matching read, and busy being asserted. When they coincide, busy must win, so no command is issued and the detector drops to idle. The bench provokes this both in a directed case and at random. It then sends another sixth-step read and expects silence from both outputs.

A second pairing is an abort whose address is also the first key. In that case a single access both ends the old sequence and starts a new one. The bench judges it by completing the new sequence from step two onward.

// File: rtl/nv_unlock_seq.sv
module nv_unlock_seq #(
  parameter logic [15:0] STORE_KEY  = 16'h8FC0,
  parameter logic [15:0] RECALL_KEY = 16'h4C63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_wr,
  input  logic [15:0] acc_addr,
  input  logic        busy,
  output logic        store_req,
  output logic        recall_req
);
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  function automatic logic [15:0] prefix_key(input logic [STEP_W-1:0] i);
    case (i)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  logic [STEP_W-1:0] step_q;
  logic              valid_q;

  wire acc_go     = acc_valid & ~valid_q;
  wire is_rd      = ~acc_wr;
  wire at_last    = (step_q == STEP_W'(PREFIX_LEN));
  wire hit_step   = is_rd && !at_last && acc_addr == prefix_key(step_q);
  wire hit_store  = is_rd && at_last && acc_addr == STORE_KEY;
  wire hit_recall = is_rd && at_last && acc_addr == RECALL_KEY;
  wire restart    = is_rd && acc_addr == prefix_key('0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q     <= '0;
      valid_q    <= 1'b0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      valid_q    <= acc_valid;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
      if (busy) begin
        step_q <= '0;
      end else if (acc_go) begin
        if (hit_step) begin
          step_q <= step_q + 1'b1;
        end else if (hit_store) begin
          store_req <= 1'b1;
          step_q    <= '0;
        end else if (hit_recall) begin
          recall_req <= 1'b1;
          step_q     <= '0;
        end else begin
          step_q <= restart ? STEP_W'(1) : '0;
        end
      end
    end
  end
endmodule

module nv_unlock_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_wr,
  input logic [15:0] acc_addr,
  input logic        busy,
  input logic        store_req,
  input logic        recall_req
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  p_store_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  p_recall_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !store_req && !recall_req);
  p_store_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(acc_valid) && !$past(acc_wr) && $past(acc_addr) == 16'h8FC0);
  p_recall_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(acc_valid) && !$past(acc_wr) && $past(acc_addr) == 16'h4C63);
endmodule

bind nv_unlock_seq nv_unlock_seq_chk u_chk (.*);

// File: tb/nv_unlock_seq_tb.sv
module nv_unlock_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_wr = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        busy = 1'b0;
  logic        store_req, recall_req;

  int checks = 0;
  int errors = 0;
  int m_step = 0;

  always #10 clk = ~clk;

  nv_unlock_seq u_dut (.*);

  function automatic logic [15:0] key(input int i);
    case (i)
      0: return 16'h4E38;
      1: return 16'hB1C7;
      2: return 16'h83E0;
      3: return 16'h7C1F;
      4: return 16'h703F;
      5: return 16'h8FC0;
      default: return 16'h4C63;
    endcase
  endfunction

  // returns expected command: 0 none, 1 store, 2 recall; updates m_step
  function automatic int model(input logic wr, input logic [15:0] a, input logic b);
    int cmd = 0;
    if (b) begin
      m_step = 0;
    end else if (!wr && m_step < 5 && a == key(m_step)) begin
      m_step = m_step + 1;
    end else if (!wr && m_step == 5 && a == key(5)) begin
      cmd = 1; m_step = 0;
    end else if (!wr && m_step == 5 && a == key(6)) begin
      cmd = 2; m_step = 0;
    end else begin
      m_step = (!wr && a == key(0)) ? 1 : 0;
    end
    return cmd;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {store,recall}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic b,
                        input int hold, input string req);
    int cmd;
    @(negedge clk);
    acc_valid = 1'b1; acc_wr = wr; acc_addr = a; busy = b;
    cmd = model(wr, a, b);
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      busy = 1'b0;
      chk("R8", {store_req, recall_req}, 2'b00);
    end
    @(negedge clk);
    acc_valid = 1'b0; busy = 1'b0;
    if (hold == 1)
      chk(req, {store_req, recall_req}, cmd == 1 ? 2'b10 : cmd == 2 ? 2'b01 : 2'b00);
    @(negedge clk);
    chk("R9", {store_req, recall_req}, 2'b00);
  endtask

  task automatic prefix(input int from);
    for (int i = from; i < 5; i++) access(1'b0, key(i), 1'b0, 1, "R4");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: {store,recall}=%b expected completion", {store_req, recall_req});
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", {store_req, recall_req}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {store_req, recall_req}, 2'b00);
    access(1'b0, key(5), 1'b0, 1, "R1");        // idle: sixth key alone does nothing

    prefix(0); access(1'b0, key(5), 1'b0, 1, "R2");
    access(1'b0, key(5), 1'b0, 1, "R10");
    prefix(0); access(1'b0, key(6), 1'b0, 1, "R3");
    access(1'b0, key(6), 1'b0, 1, "R10");
    // R4 stray read aborts
    prefix(0); access(1'b0, 16'h1234, 1'b0, 1, "R4"); access(1'b0, key(5), 1'b0, 1, "R4");
    prefix(0); access(1'b0, key(3), 1'b0, 1, "R4"); prefix(1); access(1'b0, key(5), 1'b0, 1, "R4");
    // R5 writes abort even when address matches
    access(1'b0, key(0), 1'b0, 1, "R5"); access(1'b1, key(1), 1'b0, 1, "R5");
    prefix(2); access(1'b0, key(5), 1'b0, 1, "R5");
    prefix(0); access(1'b1, key(5), 1'b0, 1, "R5");
    // R6 aborting read at first key restarts
    prefix(0); access(1'b0, key(0), 1'b0, 1, "R6");
    prefix(1); access(1'b0, key(6), 1'b0, 1, "R6");
    // R7 busy coinciding with sixth access
    prefix(0); access(1'b0, key(5), 1'b1, 1, "R7");
    access(1'b0, key(5), 1'b0, 1, "R7");
    prefix(0); busy = 1'b1; @(negedge clk); busy = 1'b0;
    m_step = 0; access(1'b0, key(6), 1'b0, 1, "R7");
    // R8 held strobe counts once
    access(1'b0, key(0), 1'b0, 1, "R8");
    access(1'b0, key(1), 1'b0, 3, "R8");
    prefix(2); access(1'b0, key(5), 1'b0, 1, "R8");

    for (int n = 0; n < 600; n++) begin
      logic wr, b;
      logic [15:0] a;
      r = $urandom_range(99);
      if (r < 70) a = (m_step == 5) ? key(5 + $urandom_range(1)) : key(m_step);
      else if (r < 85) a = key($urandom_range(6));
      else a = 16'($urandom);
      wr = ($urandom_range(99) < 8);
      b  = ($urandom_range(99) < 4);
      access(wr, a, b, 1, "R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule